// File: doc/BRIEF.md
# Watchdog Reset Pulse Generator

This block is a system watchdog. An 8-bit counter advances on a prescaled clock from the moment the external reset is released; no software action is needed to arm it. Software keeps the system alive by writing a two-step unlock sequence to a key register, which clears the counter. The watchdog fires if the counter overflows or if software writes a wrong value to the key register or a wrong check pattern to the control register.

When the watchdog fires, it pulls an active-low reset drive output low for exactly eight clocks, so that components outside the chip are reset as well. A board strap decides whether the disable bit in the control register is honoured. During the pulse the whole watchdog is held in its reset state. After the pulse it starts again from zero with the default control settings. The external reset input acts as the block's own synchronous reset. A combined system-reset request output is high while the external reset is low or while the pulse is being driven.

Top module: `wdog_rstgen`

## Requirements
- R1: While `extRstN` is low, `rstDriveN` is 1 and `sysRst` is 1. After release, `sysRst` is 0, the watchdog counts with no software action, the divider is 1 and disable is off.
- R2: With divider D, the first edge after release counts as edge 1, and the pulse starts on edge 256·D unless the counter is cleared first.
- R3: A key write (`wrSel`=0) of 0x55 arms the unlock. A following key write of 0xAA clears the counter, takes effect on that edge, and disarms. A repeated 0x55 keeps the unlock armed. A 0xAA with no prior 0x55 has no effect.
- R4: A key write of any value other than 0x55 or 0xAA starts the reset pulse on that edge.
- R5: A control write (`wrSel`=1) whose bits [5:3] are not 3'b101 starts the reset pulse on that edge.
- R6: A legal control write loads bits [2:0] as the divider select s, giving divide-by-2^s. The value 7 is clamped to 64. The write also restarts the prescaler phase, and from that edge a tick occurs every D clocks.
- R7: With `strapDisAllow`=1, a legal control write with bit 6 set freezes the counter and raises no pulse. Clearing bit 6 resumes counting from the frozen value.
- R8: With `strapDisAllow`=0, bit 6 has no effect and the watchdog keeps counting.
- R9: A pulse drives `rstDriveN` low for exactly 8 cycles, starting on the firing edge. `sysRst` is 1 throughout, and a firing cause raised during a pulse neither extends it nor adds a second one.
- R10: During the pulse, writes are ignored and all state is held at reset. After the pulse, counting restarts from zero at divide-by-1, so without writes the next pulse starts 264 cycles after the previous one.
- R11: `extRstN` held low for one cycle resets the counter, key state and control. `sysRst` follows it at once.
- R12: A legal 0xAA unlock on the same edge as an overflow wins: there is no pulse, and the counter restarts from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| extRstN | input | 1 | External active-low reset, synchronous |
| strapDisAllow | input | 1 | Board strap, 1 allows software disable |
| wrEn | input | 1 | Register write strobe |
| wrSel | input | 1 | 0 selects the key register, 1 selects the control register |
| wrData | input | 8 | Write data |
| rstDriveN | output | 1 | Active-low reset pin pull-down, low for the pulse |
| sysRst | output | 1 | System reset request, external reset or pulse |

## Verification
The counter overflow and a key-register write can land on the same clock edge. The bench provokes this by counting cycles from reset release and placing the write on exactly edge 256. A legal 0xAA completing an unlock on that edge must suppress the pulse, which the bench judges by the next pulse starting 512 cycles after release. An illegal key value on that edge must give one pulse of eight cycles starting on edge 256, not two pulses and not a longer one.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  // strobes from control to datapath
  typedef struct packed {
    logic holdRst;  // pulse in progress: hold counter and prescaler at zero
    logic clrCnt;   // legal unlock completed
    logic clrPre;   // legal control write: restart prescaler phase
    logic cntEn;    // counting permitted
  } wdStrobe_t;
endpackage

// File: rtl/wdog_dp.sv
module wdog_dp
  import wdog_pkg::*;
#(
  parameter int CNT_W       = 8,
  parameter int SEL_W       = 3,
  parameter int MAX_DIV_LOG = 6
) (
  input  logic             clk,
  input  logic             rstN,
  input  wdStrobe_t        st,
  input  logic [SEL_W-1:0] sel,
  output logic             ovf
);
  localparam int PRE_W  = MAX_DIV_LOG;
  localparam int N_SEL  = 2 ** SEL_W;

  logic [PRE_W-1:0] lastTab [N_SEL];
  logic [PRE_W-1:0] preCnt;
  logic [CNT_W-1:0] cnt;
  logic             tick;

  // divider terminal value per select code, clamped above the largest ratio
  for (genvar g = 0; g < N_SEL; g++) begin : g_div
    if (g > MAX_DIV_LOG) begin : g_clamp
      assign lastTab[g] = {PRE_W{1'b1}};
    end else begin : g_pow
      assign lastTab[g] = PRE_W'((1 << g) - 1);
    end
  end

  assign tick = st.cntEn && (preCnt == lastTab[sel]);
  assign ovf  = tick && (cnt == {CNT_W{1'b1}});

  always_ff @(posedge clk) begin
    if (!rstN || st.holdRst || st.clrPre) begin
      preCnt <= '0;
    end else if (st.cntEn) begin
      preCnt <= tick ? '0 : preCnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN || st.holdRst || st.clrCnt) begin
      cnt <= '0;
    end else if (tick) begin
      cnt <= cnt + 1'b1;
    end
  end

  // R10: pulse holds both counters at zero
  assert_hold_zero_R10: assert property (@(posedge clk) disable iff (!rstN)
    st.holdRst |=> (cnt == '0 && preCnt == '0));
  // R3: completed unlock leaves the counter at zero
  assert_kick_clear_R3: assert property (@(posedge clk) disable iff (!rstN)
    st.clrCnt |=> (cnt == '0));
  // R7: counter frozen while counting is off
  assert_off_frozen_R7: assert property (@(posedge clk) disable iff (!rstN)
    (!st.cntEn && !st.holdRst && !st.clrCnt) |=> $stable(cnt));
endmodule

// File: rtl/wdog_ctrl.sv
module wdog_ctrl
  import wdog_pkg::*;
#(
  parameter int          DATA_W    = 8,
  parameter int          SEL_W     = 3,
  parameter int          PULSE_LEN = 8,
  parameter int          DIS_BIT   = 6,
  parameter int          CHK_LSB   = 3,
  parameter int          CHK_W     = 3,
  parameter logic [CHK_W-1:0]  CHK_VAL  = 3'b101,
  parameter logic [DATA_W-1:0] KEY_ARM  = 8'h55,
  parameter logic [DATA_W-1:0] KEY_FIRE = 8'hAA
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              strapDisAllow,
  input  logic              wrEn,
  input  logic              wrSel,
  input  logic [DATA_W-1:0] wrData,
  input  logic              ovf,
  output wdStrobe_t         st,
  output logic [SEL_W-1:0]  sel,
  output logic              rstDriveN
);
  localparam int PLS_W = $clog2(PULSE_LEN + 1);
  localparam logic [PLS_W-1:0] PLS_LOAD = PLS_W'(PULSE_LEN);

  logic [PLS_W-1:0] pulseCnt;
  logic busy, keyWr, ctlWr, badKey, badCtl, goodCtl, kickClr, fire;
  logic armed, disBit;

  assign busy    = (pulseCnt != '0);
  assign keyWr   = wrEn && !wrSel && !busy;
  assign ctlWr   = wrEn &&  wrSel && !busy;
  assign badKey  = keyWr && (wrData != KEY_ARM) && (wrData != KEY_FIRE);
  assign badCtl  = ctlWr && (wrData[CHK_LSB +: CHK_W] != CHK_VAL);
  assign goodCtl = ctlWr && !badCtl;
  assign kickClr = keyWr && (wrData == KEY_FIRE) && armed;
  // a completed unlock on the overflow edge wins over the overflow
  assign fire    = (ovf && !kickClr) || badKey || badCtl;

  always_ff @(posedge clk) begin
    if (!rstN || busy) begin
      armed <= 1'b0;
    end else if (keyWr) begin
      if (wrData == KEY_ARM) begin
        armed <= 1'b1;
      end else if (wrData == KEY_FIRE) begin
        armed <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN || busy) begin
      disBit <= 1'b0;
      sel    <= '0;
    end else if (goodCtl) begin
      disBit <= wrData[DIS_BIT];
      sel    <= wrData[SEL_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pulseCnt <= '0;
    end else if (fire) begin
      pulseCnt <= PLS_LOAD;
    end else if (busy) begin
      pulseCnt <= pulseCnt - 1'b1;
    end
  end

  always_comb begin
    st.holdRst = busy;
    st.clrCnt  = kickClr;
    st.clrPre  = goodCtl;
    st.cntEn   = !busy && !(disBit && strapDisAllow);
  end

  assign rstDriveN = !busy;

  // R4: illegal key value starts a pulse on that edge
  assert_bad_key_R4: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && !wrSel && rstDriveN && wrData != KEY_ARM && wrData != KEY_FIRE)
      |=> !rstDriveN);
  // R5: wrong check bits start a pulse on that edge
  assert_bad_ctrl_R5: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrSel && rstDriveN && wrData[CHK_LSB +: CHK_W] != CHK_VAL)
      |=> !rstDriveN);
  // R2: an overflow with no write on that edge fires
  assert_ovf_fires_R2: assert property (@(posedge clk) disable iff (!rstN)
    (ovf && !wrEn) |=> !rstDriveN);
  // R9: pulse begins with the full length loaded
  assert_pulse_load_R9: assert property (@(posedge clk) disable iff (!rstN)
    $fell(rstDriveN) |-> (pulseCnt == PLS_LOAD));
  // R9: pulse shortens by one each cycle, never reloads
  assert_pulse_shrink_R9: assert property (@(posedge clk) disable iff (!rstN)
    busy |=> (pulseCnt == PLS_W'($past(pulseCnt) - 1'b1)));
endmodule

// File: rtl/wdog_rstgen.sv
module wdog_rstgen
  import wdog_pkg::*;
#(
  parameter int CNT_W       = 8,
  parameter int SEL_W       = 3,
  parameter int MAX_DIV_LOG = 6,
  parameter int DATA_W      = 8,
  parameter int PULSE_LEN   = 8
) (
  input  logic              clk,
  input  logic              extRstN,
  input  logic              strapDisAllow,
  input  logic              wrEn,
  input  logic              wrSel,
  input  logic [DATA_W-1:0] wrData,
  output logic              rstDriveN,
  output logic              sysRst
);
  wdStrobe_t        st;
  logic [SEL_W-1:0] sel;
  logic             ovf;

  wdog_ctrl #(
    .DATA_W(DATA_W), .SEL_W(SEL_W), .PULSE_LEN(PULSE_LEN)
  ) u_ctrl (
    .clk(clk), .rstN(extRstN), .strapDisAllow(strapDisAllow),
    .wrEn(wrEn), .wrSel(wrSel), .wrData(wrData), .ovf(ovf),
    .st(st), .sel(sel), .rstDriveN(rstDriveN)
  );

  wdog_dp #(
    .CNT_W(CNT_W), .SEL_W(SEL_W), .MAX_DIV_LOG(MAX_DIV_LOG)
  ) u_dp (
    .clk(clk), .rstN(extRstN), .st(st), .sel(sel), .ovf(ovf)
  );

  assign sysRst = !extRstN || !rstDriveN;
endmodule

// File: tb/wdog_rstgen_tb.sv
`timescale 1ns/1ps
module wdog_rstgen_tb;
  logic       clk = 1'b0;
  logic       extRstN = 1'b0;
  logic       strapDisAllow = 1'b0;
  logic       wrEn = 1'b0;
  logic       wrSel = 1'b0;
  logic [7:0] wrData = 8'h00;
  logic       rstDriveN, sysRst;

  int cyc = 0;
  int total = 0;
  int bad = 0;
  int relCyc = 0;
  int pulses = 0;
  bit finished = 0;

  // scoreboard of expected pulse starts
  int    expStart[$];
  string expTag[$];
  bit    inPulse = 0;
  int    pStart = 0;
  int    pLen = 0;
  bit    sysOk = 1;

  always #2.5 clk = ~clk;  // 200 MHz
  always @(posedge clk) cyc <= cyc + 1;

  wdog_rstgen u_dut (
    .clk(clk), .extRstN(extRstN), .strapDisAllow(strapDisAllow),
    .wrEn(wrEn), .wrSel(wrSel), .wrData(wrData),
    .rstDriveN(rstDriveN), .sysRst(sysRst)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  task automatic expectPulse(input int start, input string tag);
    expStart.push_back(start);
    expTag.push_back(tag);
  endtask

  // monitor: measure each pulse and compare against the queue head
  always @(negedge clk) begin
    if (!rstDriveN) begin
      if (!inPulse) begin
        inPulse = 1;
        pStart  = cyc;
        pLen    = 0;
        sysOk   = 1;
      end
      pLen++;
      if (!sysRst) sysOk = 0;
    end else if (inPulse) begin
      inPulse = 0;
      pulses++;
      if (expStart.size() == 0) begin
        check(0, "R9 unexpected pulse start", pStart, -1);
      end else begin
        int    e;
        string t;
        e = expStart.pop_front();
        t = expTag.pop_front();
        check(pStart == e, {t, " start"}, pStart, e);
        check(pLen == 8, "R9 pulse length", pLen, 8);
        check(sysOk, "R9 sysRst during pulse", 0, 1);
      end
    end
  end

  task automatic wrAt(input int edgeN, input bit s, input logic [7:0] d);
    while (cyc < edgeN - 1) @(negedge clk);
    wrEn = 1'b1; wrSel = s; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic waitPulses();
    do begin
      @(negedge clk); #1;
    end while (expStart.size() != 0 || inPulse);
  endtask

  task automatic doReset();
    @(negedge clk);
    extRstN = 1'b0;
    repeat (2) @(negedge clk);
    extRstN = 1'b1;
    relCyc = cyc;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog expired actual=%0d expected=0", cyc);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int s1, s2, w, pc;
    // R1 reset state
    repeat (3) @(negedge clk);
    #1;
    check(rstDriveN == 1'b1, "R1 rstDriveN in reset", rstDriveN, 1);
    check(sysRst == 1'b1, "R1 sysRst in reset", sysRst, 1);
    extRstN = 1'b1;
    relCyc = cyc;
    @(negedge clk); #1;
    check(sysRst == 1'b0, "R1 sysRst after release", sysRst, 0);
    check(rstDriveN == 1'b1, "R1 rstDriveN after release", rstDriveN, 1);

    // R2 overflow at divide-by-1, R10 restart period and ignored write in pulse
    s1 = relCyc + 256;
    s2 = s1 + 264;
    expectPulse(s1, "R2 overflow div1");
    expectPulse(s2, "R10 restart after pulse");
    wrAt(s2 + 2, 1'b0, 8'h12);  // inside the pulse: must be ignored
    waitPulses();

    // R3 unlock, with a repeated arm value
    doReset();
    wrAt(relCyc + 100, 1'b0, 8'h55);
    wrAt(relCyc + 101, 1'b0, 8'h55);
    wrAt(relCyc + 102, 1'b0, 8'hAA);
    expectPulse(relCyc + 102 + 256, "R3 unlock clears counter");
    waitPulses();

    // R3 lone 0xAA has no effect
    doReset();
    wrAt(relCyc + 100, 1'b0, 8'hAA);
    expectPulse(relCyc + 256, "R3 lone AA ignored");
    waitPulses();

    // R4 illegal key value
    doReset();
    wrAt(relCyc + 50, 1'b0, 8'h12);
    expectPulse(relCyc + 50, "R4 bad key");
    waitPulses();

    // R5 wrong check bits
    doReset();
    wrAt(relCyc + 40, 1'b1, 8'h00);
    expectPulse(relCyc + 40, "R5 bad ctrl check");
    waitPulses();

    // R6 divide-by-4
    doReset();
    w = relCyc + 10;
    wrAt(w, 1'b1, 8'h2A);
    wrAt(w + 1, 1'b0, 8'h55);
    wrAt(w + 2, 1'b0, 8'hAA);
    expectPulse(w + 1024, "R6 divide by 4");
    waitPulses();

    // R6 select 7 clamps to divide-by-64
    doReset();
    w = relCyc + 10;
    wrAt(w, 1'b1, 8'h2F);
    wrAt(w + 1, 1'b0, 8'h55);
    wrAt(w + 2, 1'b0, 8'hAA);
    expectPulse(w + 16384, "R6 select 7 clamps to 64");
    waitPulses();

    // R7 disable allowed by strap: frozen, then resumes from frozen count
    strapDisAllow = 1'b1;
    doReset();
    wrAt(relCyc + 10, 1'b1, 8'h68);
    pc = pulses;
    w = relCyc + 700;
    while (cyc < w - 1) @(negedge clk);
    #1;
    check(pulses == pc && !inPulse, "R7 no pulse while disabled", pulses, pc);
    wrAt(w, 1'b1, 8'h28);
    expectPulse(w + 246, "R7 resume from frozen count");
    waitPulses();

    // R8 strap low: disable bit ignored
    strapDisAllow = 1'b0;
    doReset();
    wrAt(relCyc + 10, 1'b1, 8'h68);
    expectPulse(relCyc + 256, "R8 disable ignored");
    waitPulses();

    // R11 one-cycle external reset
    doReset();
    while (cyc < relCyc + 99) @(negedge clk);
    extRstN = 1'b0;
    #1;
    check(sysRst == 1'b1, "R11 sysRst follows extRstN", sysRst, 1);
    @(negedge clk);
    extRstN = 1'b1;
    relCyc = cyc;
    expectPulse(relCyc + 256, "R11 counter reset by extRstN");
    waitPulses();

    // R12 legal unlock on the overflow edge wins
    doReset();
    wrAt(relCyc + 255, 1'b0, 8'h55);
    wrAt(relCyc + 256, 1'b0, 8'hAA);
    expectPulse(relCyc + 512, "R12 unlock beats overflow");
    waitPulses();

    // R4 with R9: illegal key on the overflow edge gives one pulse only
    doReset();
    wrAt(relCyc + 256, 1'b0, 8'h12);
    expectPulse(relCyc + 256, "R4 bad key on overflow edge");
    waitPulses();
    pc = pulses;
    repeat (20) @(negedge clk);
    #1;
    check(pulses == pc && !inPulse, "R9 no second pulse", pulses, pc);

    check(expStart.size() == 0, "R9 all expected pulses seen", expStart.size(), 0);
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule